// File: doc/BRIEF.md
# Per-Pixel Bunch-Synchronous Event Sequencer

This block is the control sequencer for one pixel of a bunch-clocked detector front end. It runs on a fast clock and sees a one-cycle bunch strobe once per bunch crossing. Two discriminator inputs drive it. The event discriminator announces a hit. The range discriminator reports that the hit is large enough to need the low-gain path. On an accepted hit the sequencer performs four steps:
- it drops the capacitor resets,
- it latches the bunch number and the running event count into the next free sample slot,
- it waits a settling time, then closes the track switch,
- it opens the track switch again to hold the sample, and re-arms on the next bunch strobe.

A pixel keeps up to four sample slots per train. The high-gain capacitor reset pulses on every idle bunch crossing. The low-gain capacitor reset is asserted only after power-up and after a processed event. `train_start` opens a train and clears all per-train state. `train_end` closes the train and freezes the slots. The frozen slots then leave through a valid/ready stream, one slot per handshake, towards the digitiser.

All delays are counted in fast-clock cycles. `SETTLE_CYC` and `HOLD_CYC` are measured from the clock edge that accepts the trigger.

Top module: `pix_evseq`

## Requirements
- R1: While reset is held, rst_lg is 1 and rst_hg, track, the three strobes, ready, out_valid and evt_count are all 0.
- R2: A rising edge of evt_disc is accepted at a clock edge where ready is 1 and neither train input is high. The edge that accepts it raises strb_time and strb_count for exactly one cycle, and ready drops.
- R3: track rises on the SETTLE_CYC-th clock edge after the accepting edge and falls on the HOLD_CYC-th edge after it.
- R4: strb_range pulses for one cycle together with the rise of track. The slot's range bit is 1 exactly when rng_disc was high at any clock edge from the accepting edge up to and including the edge that raises track.
- R5: rst_hg is a one-cycle pulse after each bx_strobe edge while the sequencer is idle and not accepting. rst_hg stays 0 from the accepting edge until re-arm.
- R6: rst_lg falls at the accepting edge. While idle, it falls at the next bx_strobe edge. It is set again at each re-arm edge.
- R7: After track falls, the first bx_strobe edge re-arms the sequencer and produces an rst_hg pulse. ready is 1 exactly when the sequencer is idle, a train is open and fewer than four slots are filled.
- R8: A rising edge of evt_disc is ignored in three cases: during an active sequence, when no train is open, or when four slots are filled. An ignored edge gives no strobe and fills no slot.
- R9: evt_count counts every rising edge of evt_disc while a train is open, including ignored ones. It saturates at 31 and is cleared by train_start.
- R10: Slots fill in order 0 to 3. Each slot stores three values:
  - the number of bx_strobe edges since train_start, counted before the accepting edge,
  - the evt_count value that includes this trigger,
  - the range bit.
- R11: After train_end the stream presents slots 0 to n-1 as out_slot, each with its stored values. The stream holds a slot stable while out_valid is 1 and out_ready is 0, and advances on out_valid and out_ready. out_valid stays 0 during a train and once all slots are sent.
- R12: A train input during settle or track aborts the sequence: track falls at that edge and the sequencer waits for the next bx_strobe to re-arm. train_start empties the slot bank and the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_strobe | input | 1 | One-cycle bunch crossing strobe |
| train_start | input | 1 | Opens a train, clears per-train state |
| train_end | input | 1 | Closes the train, freezes the slots |
| evt_disc | input | 1 | Event discriminator |
| rng_disc | input | 1 | Range discriminator |
| rst_hg | output | 1 | High-gain capacitor reset pulse |
| rst_lg | output | 1 | Low-gain capacitor reset level |
| track | output | 1 | Track switch closed |
| strb_time | output | 1 | Bunch-number latch strobe |
| strb_range | output | 1 | Range latch strobe |
| strb_count | output | 1 | Event counter strobe |
| ready | output | 1 | Pixel armed for a new trigger |
| evt_count | output | EVCNT_W | Saturating event count of the train |
| out_valid | output | 1 | Frozen slot available |
| out_ready | input | 1 | Digitiser accepts the slot |
| out_slot | output | SW | Slot index |
| out_bunch | output | BUNCH_W | Stored bunch number |
| out_range | output | 1 | Stored range bit |
| out_evcnt | output | EVCNT_W | Stored event count |

## Verification
The bound checker watches four properties on every cycle:
- track and rst_hg are never high together;
- every rst_hg pulse and every rise of rst_lg follows a bunch strobe;
- strobes only follow a cycle with ready high, and strb_range only comes with track;
- a closed track switch never lasts longer than HOLD_CYC minus SETTLE_CYC cycles.

The checker also holds that a stalled output slot stays stable. Some behaviour needs the bench's scenarios to show it: the exact settle and hold edges, the range window, slot order and contents, counter saturation, full-bank and no-train rejection, and aborts by the train inputs.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_TRACK  = 2'd2,
    SEQ_REARM  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/pes_sat_cnt.sv
module pes_sat_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) val <= '0;
    else if (inc && (val != {W{1'b1}})) val <= val + 1'b1;
  end
endmodule

// File: rtl/pes_slot_bank.sv
module pes_slot_bank #(
  parameter int SLOTS = 4,
  parameter int BW    = 12,
  parameter int CW    = 5,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int PW   = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [BW-1:0] wr_bunch,
  input  logic [CW-1:0] wr_cnt,
  input  logic          rng_wr,
  input  logic          rng_val,
  input  logic          freeze,
  input  logic          rd_ready,
  output logic          full,
  output logic          rd_valid,
  output logic [SW-1:0] rd_idx,
  output logic [BW-1:0] rd_bunch,
  output logic          rd_range,
  output logic [CW-1:0] rd_cnt
);
  logic [PW-1:0]       wr_ptr, rd_ptr;
  logic [SLOTS*BW-1:0] b_flat;
  logic [SLOTS*CW-1:0] c_flat;
  logic [SLOTS-1:0]    r_flat;

  for (genvar g = 0; g < SLOTS; g++) begin : gen_slot
    logic [BW-1:0] b_q;
    logic [CW-1:0] c_q;
    logic          r_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        b_q <= '0;
        c_q <= '0;
        r_q <= 1'b0;
      end else if (wr && wr_ptr == PW'(g)) begin
        b_q <= wr_bunch;
        c_q <= wr_cnt;
        r_q <= 1'b0;
      end else if (rng_wr && wr_ptr == PW'(g + 1)) begin
        r_q <= rng_val;
      end
    end
    assign b_flat[g*BW +: BW] = b_q;
    assign c_flat[g*CW +: CW] = c_q;
    assign r_flat[g]          = r_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr && !full) wr_ptr <= wr_ptr + 1'b1;
      if (rd_valid && rd_ready) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign full     = (wr_ptr == PW'(SLOTS));
  assign rd_valid = freeze && (rd_ptr < wr_ptr);
  assign rd_idx   = SW'(rd_ptr);
  assign rd_bunch = b_flat[rd_idx*BW +: BW];
  assign rd_cnt   = c_flat[rd_idx*CW +: CW];
  assign rd_range = r_flat[rd_idx];
endmodule

// File: rtl/pix_evseq.sv
module pix_evseq
  import pes_pkg::*;
#(
  parameter int BUNCH_W    = 12,
  parameter int EVCNT_W    = 5,
  parameter int SLOTS      = 4,
  parameter int SETTLE_CYC = 15,
  parameter int HOLD_CYC   = 100,
  localparam int SW        = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int TMR_W     = $clog2(HOLD_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bx_strobe,
  input  logic               train_start,
  input  logic               train_end,
  input  logic               evt_disc,
  input  logic               rng_disc,
  output logic               rst_hg,
  output logic               rst_lg,
  output logic               track,
  output logic               strb_time,
  output logic               strb_range,
  output logic               strb_count,
  output logic               ready,
  output logic [EVCNT_W-1:0] evt_count,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SW-1:0]      out_slot,
  output logic [BUNCH_W-1:0] out_bunch,
  output logic               out_range,
  output logic [EVCNT_W-1:0] out_evcnt
);
  seq_st_t            st;
  logic [TMR_W-1:0]   tmr;
  logic               rng_acc, evt_q, train_act, frozen;
  logic [BUNCH_W-1:0] bunch;
  logic [EVCNT_W-1:0] ev_nxt;
  logic               full, trig_edge, abort, accept, ev_inc, rng_wr;

  assign trig_edge = evt_disc && !evt_q;
  assign abort     = train_start || train_end;
  assign ev_inc    = trig_edge && train_act && !abort;
  assign accept    = ev_inc && (st == SEQ_IDLE) && !full;
  assign ev_nxt    = (evt_count == {EVCNT_W{1'b1}}) ? evt_count : evt_count + 1'b1;
  assign rng_wr    = (st == SEQ_SETTLE) && !abort && (tmr == TMR_W'(SETTLE_CYC));
  assign ready     = (st == SEQ_IDLE) && train_act && !full;

  pes_sat_cnt #(.W(BUNCH_W)) u_bunch_cnt (
    .clk(clk), .rst_n(rst_n), .clr(train_start),
    .inc(bx_strobe && train_act), .val(bunch)
  );

  pes_sat_cnt #(.W(EVCNT_W)) u_evt_cnt (
    .clk(clk), .rst_n(rst_n), .clr(train_start),
    .inc(ev_inc), .val(evt_count)
  );

  pes_slot_bank #(.SLOTS(SLOTS), .BW(BUNCH_W), .CW(EVCNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .clr(train_start),
    .wr(accept), .wr_bunch(bunch), .wr_cnt(ev_nxt),
    .rng_wr(rng_wr), .rng_val(rng_acc || rng_disc),
    .freeze(frozen), .rd_ready(out_ready), .full(full),
    .rd_valid(out_valid), .rd_idx(out_slot), .rd_bunch(out_bunch),
    .rd_range(out_range), .rd_cnt(out_evcnt)
  );

  // Train window and freeze flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      train_act <= 1'b0;
      frozen    <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= evt_disc;
      if (train_start) begin
        train_act <= 1'b1;
        frozen    <= 1'b0;
      end else if (train_end) begin
        train_act <= 1'b0;
        frozen    <= 1'b1;
      end
    end
  end

  // Settle / track / hold / re-arm sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SEQ_IDLE;
      tmr        <= '0;
      rng_acc    <= 1'b0;
      track      <= 1'b0;
      rst_hg     <= 1'b0;
      rst_lg     <= 1'b1;
      strb_time  <= 1'b0;
      strb_count <= 1'b0;
      strb_range <= 1'b0;
    end else begin
      rst_hg     <= 1'b0;
      strb_time  <= 1'b0;
      strb_count <= 1'b0;
      strb_range <= 1'b0;
      unique case (st)
        SEQ_IDLE: begin
          if (accept) begin
            st         <= SEQ_SETTLE;
            tmr        <= TMR_W'(1);
            rng_acc    <= rng_disc;
            rst_lg     <= 1'b0;
            strb_time  <= 1'b1;
            strb_count <= 1'b1;
          end else if (bx_strobe) begin
            rst_hg <= 1'b1;
            rst_lg <= 1'b0;
          end
        end
        SEQ_SETTLE: begin
          if (abort) begin
            st <= SEQ_REARM;
          end else begin
            tmr     <= tmr + 1'b1;
            rng_acc <= rng_acc || rng_disc;
            if (tmr == TMR_W'(SETTLE_CYC)) begin
              st         <= SEQ_TRACK;
              track      <= 1'b1;
              strb_range <= 1'b1;
            end
          end
        end
        SEQ_TRACK: begin
          if (abort || tmr == TMR_W'(HOLD_CYC)) begin
            st    <= SEQ_REARM;
            track <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SEQ_REARM: begin
          if (bx_strobe) begin
            st     <= SEQ_IDLE;
            rst_hg <= 1'b1;
            rst_lg <= 1'b1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_evseq_chk.sv
module pix_evseq_chk #(
  parameter int BUNCH_W    = 12,
  parameter int EVCNT_W    = 5,
  parameter int SW         = 2,
  parameter int SETTLE_CYC = 15,
  parameter int HOLD_CYC   = 100,
  localparam int LW        = $clog2(HOLD_CYC + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bx_strobe,
  input logic               train_start,
  input logic               rst_hg,
  input logic               rst_lg,
  input logic               track,
  input logic               strb_time,
  input logic               strb_range,
  input logic               ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SW-1:0]      out_slot,
  input logic [BUNCH_W-1:0] out_bunch,
  input logic               out_range,
  input logic [EVCNT_W-1:0] out_evcnt
);
  logic [LW-1:0] track_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !track) track_run <= '0;
    else if (track_run != {LW{1'b1}}) track_run <= track_run + 1'b1;
  end

  p_no_hg_in_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    track |-> !rst_hg);
  p_hg_after_bx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hg |-> $past(bx_strobe));
  p_lg_rise_on_bx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_lg) |-> $past(bx_strobe));
  p_strobe_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb_time |-> $past(ready));
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    track |-> !ready);
  p_range_with_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb_range |-> track);
  p_track_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    track_run <= LW'(HOLD_CYC - SETTLE_CYC));
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !train_start) |=>
      (out_valid && $stable({out_slot, out_bunch, out_range, out_evcnt})));
endmodule

bind pix_evseq pix_evseq_chk #(
  .BUNCH_W(BUNCH_W), .EVCNT_W(EVCNT_W), .SW(SW),
  .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .train_start(train_start),
  .rst_hg(rst_hg), .rst_lg(rst_lg), .track(track), .strb_time(strb_time),
  .strb_range(strb_range), .ready(ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_slot(out_slot), .out_bunch(out_bunch),
  .out_range(out_range), .out_evcnt(out_evcnt)
);

// File: tb/pix_evseq_tb.sv
module pix_evseq_tb;
  localparam int S   = 4;
  localparam int H   = 12;
  localparam int BXP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bx_strobe = 1'b0, train_start = 1'b0, train_end = 1'b0;
  logic evt_disc = 1'b0, rng_disc = 1'b0, out_ready = 1'b0;
  logic rst_hg, rst_lg, track, strb_time, strb_range, strb_count, ready, out_valid, out_range;
  logic [4:0]  evt_count, out_evcnt;
  logic [1:0]  out_slot;
  logic [11:0] out_bunch;

  int checks = 0, errors = 0;
  bit cmp_en = 0, done = 0;

  always #10 clk = ~clk;

  pix_evseq #(.SETTLE_CYC(S), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .train_start(train_start),
    .train_end(train_end), .evt_disc(evt_disc), .rng_disc(rng_disc),
    .rst_hg(rst_hg), .rst_lg(rst_lg), .track(track), .strb_time(strb_time),
    .strb_range(strb_range), .strb_count(strb_count), .ready(ready),
    .evt_count(evt_count), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot(out_slot), .out_bunch(out_bunch), .out_range(out_range),
    .out_evcnt(out_evcnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  int m_phase, m_tmr, m_used, m_bunch, m_cnt;
  bit m_act, m_prev, m_racc, m_ready, m_track, m_hg, m_lg, m_st, m_sr;
  int m_b[4], m_c[4], m_r[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_tmr = 0; m_used = 0; m_bunch = 0; m_cnt = 0;
      m_act = 0; m_prev = 0; m_racc = 0; m_track = 0; m_hg = 0; m_lg = 1;
      m_st = 0; m_sr = 0;
      for (int i = 0; i < 4; i++) begin m_b[i] = 0; m_c[i] = 0; m_r[i] = 0; end
    end else begin
      bit edge_v, acc;
      edge_v = evt_disc && !m_prev;
      m_prev = evt_disc;
      acc = (m_phase == 0) && edge_v && m_act && !train_start && !train_end && (m_used < 4);
      m_hg = 0; m_st = 0; m_sr = 0;
      if (train_start) begin
        m_bunch = 0; m_cnt = 0; m_used = 0;
        for (int i = 0; i < 4; i++) begin m_b[i] = 0; m_c[i] = 0; m_r[i] = 0; end
      end else begin
        if (edge_v && m_act && !train_end && m_cnt < 31) m_cnt++;
        if (acc) begin
          m_b[m_used] = m_bunch; m_c[m_used] = m_cnt; m_r[m_used] = 0; m_used++;
        end
        if (bx_strobe && m_act && m_bunch < 4095) m_bunch++;
      end
      case (m_phase)
        0: if (acc) begin
             m_phase = 1; m_tmr = 1; m_racc = rng_disc; m_lg = 0; m_st = 1;
           end else if (bx_strobe) begin
             m_hg = 1; m_lg = 0;
           end
        1: if (train_start || train_end) begin
             m_phase = 2; m_track = 0;
           end else begin
             if (m_tmr == S) begin
               m_r[m_used-1] = int'(m_racc || rng_disc); m_track = 1; m_sr = 1;
             end
             m_racc = m_racc || rng_disc;
             if (m_tmr == H) begin m_track = 0; m_phase = 2; end
             m_tmr++;
           end
        default: if (bx_strobe) begin m_phase = 0; m_hg = 1; m_lg = 1; end
      endcase
      if (train_start) m_act = 1;
      else if (train_end) m_act = 0;
      m_ready = (m_phase == 0) && m_act && (m_used < 4);
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(ready == m_ready, "R7 ready", int'(ready), int'(m_ready));
      chk(track == m_track, "R3 track", int'(track), int'(m_track));
      chk(rst_hg == m_hg, "R5 rst_hg", int'(rst_hg), int'(m_hg));
      chk(rst_lg == m_lg, "R6 rst_lg", int'(rst_lg), int'(m_lg));
      chk(strb_time == m_st && strb_count == m_st, "R2 strobes", int'(strb_time), int'(m_st));
      chk(strb_range == m_sr, "R4 strb_range", int'(strb_range), int'(m_sr));
      chk(int'(evt_count) == m_cnt, "R9 evt_count", int'(evt_count), m_cnt);
    end
  end

  // Bunch strobe generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      bx_strobe = rst_n && (ph == 0);
      ph = (ph + 1) % BXP;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ts(); train_start = 1; cyc(1); train_start = 0; endtask
  task automatic pulse_te(); train_end = 1; cyc(1); train_end = 0; endtask

  task automatic hit(input int w, input bit r);
    evt_disc = 1; rng_disc = r; cyc(w); evt_disc = 0; rng_disc = 0; cyc(1);
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!ready && g < 200) begin cyc(1); g++; end
  endtask

  int got_r[4];

  task automatic drain();
    int beats = 0, guard = 0;
    bit hs = 0, pv = 0;
    logic [19:0] sv = '0;
    while (guard < 400) begin
      cyc(1); guard++;
      if (hs) beats++;
      if (pv) chk(out_valid && {out_slot, out_bunch, out_range, out_evcnt} == sv,
                  "R11 stall hold", int'(out_bunch), int'(sv[17:6]));
      if (out_valid && beats < 4) begin
        chk(int'(out_slot) == beats, "R11 order", int'(out_slot), beats);
        chk(int'(out_bunch) == m_b[beats], "R10 bunch", int'(out_bunch), m_b[beats]);
        chk(int'(out_evcnt) == m_c[beats], "R10 evcnt", int'(out_evcnt), m_c[beats]);
        chk(int'(out_range) == m_r[beats], "R4 range bit", int'(out_range), m_r[beats]);
        got_r[beats] = int'(out_range);
      end else if (!out_valid && beats >= m_used) begin
        break;
      end
      out_ready = 1'($urandom_range(0, 1));
      hs = out_valid && out_ready;
      pv = out_valid && !out_ready;
      sv = {out_slot, out_bunch, out_range, out_evcnt};
    end
    out_ready = 0;
    chk(beats == m_used, "R11 beat count", beats, m_used);
  endtask

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    chk(rst_lg == 1 && rst_hg == 0 && track == 0, "R1 reset caps", int'(rst_lg), 1);
    chk(ready == 0 && out_valid == 0 && evt_count == 0, "R1 reset status", int'(ready), 0);
    chk(strb_time == 0 && strb_range == 0 && strb_count == 0, "R1 reset strobes", int'(strb_time), 0);
    rst_n = 1;
    cyc(1);
    cmp_en = 1;

    // R8: triggers with no open train
    hit(2, 1); hit(1, 0); cyc(8);
    chk(evt_count == 0 && !track, "R8 no train", int'(evt_count), 0);

    // R3/R4 directed timing with early range
    pulse_ts(); cyc(3);
    begin
      int n = 0;
      evt_disc = 1; rng_disc = 1;
      while (!strb_time && n < 20) begin cyc(1); n++; end
      evt_disc = 0; rng_disc = 0;
      n = 0;
      while (!track && n < 50) begin cyc(1); n++; end
      chk(n == S, "R3 settle edges", n, S);
      chk(strb_range == 1, "R4 strobe with track", int'(strb_range), 1);
      while (track && n < 80) begin cyc(1); n++; end
      chk(n == H, "R3 hold edges", n, H);
    end
    // second hit: range only after track rose
    wait_ready(); hit(1, 0); cyc(S + 1); rng_disc = 1; cyc(2); rng_disc = 0;
    hit(1, 0); hit(1, 0);   // R8: during active sequence
    wait_ready(); hit(2, 0);
    wait_ready(); hit(1, 1);
    wait_ready();
    chk(ready == 0, "R7 full bank", int'(ready), 0);
    for (int i = 0; i < 40; i++) hit(1, 0);  // R8 ignored, R9 saturates
    chk(evt_count == 31, "R9 saturation", int'(evt_count), 31);
    chk(m_used == 4, "R8 slots after full", m_used, 4);
    cyc(20); pulse_te(); drain();
    chk(got_r[0] == 1, "R4 early range", got_r[0], 1);
    chk(got_r[1] == 0, "R4 late range", got_r[1], 0);

    // R12 abort during settle
    pulse_ts();
    chk(out_valid == 0, "R12 stream cleared", int'(out_valid), 0);
    cyc(2); hit(1, 1); pulse_te();
    chk(track == 0, "R12 abort track", int'(track), 0);
    drain();
    pulse_ts(); cyc(1);
    chk(evt_count == 0 && out_valid == 0, "R12 new train", int'(evt_count), 0);
    cyc(10); pulse_te(); drain();

    // Constrained random trains
    for (int t = 0; t < 8; t++) begin
      pulse_ts();
      for (int e = 0; e < int'($urandom_range(1, 8)); e++) begin
        cyc($urandom_range(1, 20));
        evt_disc = 1; rng_disc = 1'($urandom_range(0, 1));
        cyc($urandom_range(1, 3));
        evt_disc = 0; rng_disc = 1'($urandom_range(0, 1));
        cyc($urandom_range(1, 4)); rng_disc = 0;
      end
      cyc($urandom_range(0, 25));
      pulse_te(); drain();
    end

    cyc(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual %0d cycles expected completion", 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule